// File: doc/BRIEF.md
# Line Timing Qualification Logic

This block decides, once per system clock, whether the transmit path may take its timing from the clock recovered on the receive path. It combines live defect indications from the receive path with loopback and forced-oscillator status. Each defect can be neutralised by its own override control. The block then produces a registered line-timing-ok flag and a two-bit transmit reference select. When line timing is not allowed, the select points to the local reference, or to the crystal-oscillator input when oscillator-only operation is chosen.

Line timing can be forced on regardless of defects. It can also be granted automatically once the recovered clock qualifies. An automatic grant is made only after the qualifying condition has held for a programmable hold-off count, so that the select does not toggle on short defect gaps. Sticky status copies of the four defects are kept apart from the live values that gate the enable. A read strobe clears them.

Top module: `ltime_qual`

## Requirements
- R1: The recovered clock is treated as unusable whenever `vco_forced` or `sys_loopback` is 1, whatever the defect and override inputs are.
- R2: Signal presence is taken as `los_n ^ xfp_inv`, so a 1 means signal present. A missing signal blocks line timing unless `ovr_los` is 1.
- R3: A live `sync_err` blocks line timing unless `ovr_sync` equals 2'b01. The values 2'b00, 2'b10 and 2'b11 give no override.
- R4: A live `lof` blocks line timing unless `ovr_lof` is 1. A live `line_ais` blocks line timing unless `ovr_ais` is 1.
- R5: The block requests line timing when `force_lt` is 1, or when `auto_lt` is 1 and the recovered clock qualifies under R1 to R4. With both `force_lt` and `auto_lt` at 0, `ltime_ok` stays 0.
- R6: Once a request is made with `force_lt` at 1, `ltime_ok` is 1 after the next clock edge, with no hold-off.
- R7: An automatic request must hold for `holdoff`+1 consecutive edges before `ltime_ok` rises, and a break in it restarts the count. `ltime_ok` falls at the first edge at which no request is present.
- R8: `tx_ref_sel` is registered along with `ltime_ok`. It is 2'b10 (recovered clock) when `ltime_ok` is 1. Otherwise it is 2'b01 (oscillator input) when `vcxo_only` is 1, or 2'b00 (local reference) when `vcxo_only` is 0.
- R9: Each sticky status bit (`stat_los`, `stat_sync`, `stat_lof`, `stat_ais`) is set one edge after its raw defect is 1. Overrides do not affect it. It clears at the edge where `stat_rd` is 1, unless its defect is still 1 in that cycle.
- R10: While `rst_n` is 0, `ltime_ok`, `tx_ref_sel`, the status bits and the hold-off count are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| los_n | input | 1 | Raw signal-present input, active-low loss |
| xfp_inv | input | 1 | Inverts the sense of `los_n` |
| sync_err | input | 1 | Live sync-error defect |
| lof | input | 1 | Live loss-of-frame defect |
| line_ais | input | 1 | Live line AIS defect |
| vco_forced | input | 1 | Receive clock recovery oscillator held in forced mode |
| sys_loopback | input | 1 | System-side loopback active |
| ovr_los | input | 1 | Override for loss of signal |
| ovr_sync | input | 2 | Sync-error override field, active only at 2'b01 |
| ovr_lof | input | 1 | Override for loss of frame |
| ovr_ais | input | 1 | Override for line AIS |
| auto_lt | input | 1 | Automatic line-timing enable |
| force_lt | input | 1 | Force line timing without qualification |
| vcxo_only | input | 1 | Fallback source is the oscillator input |
| holdoff | input | CW | Qualification hold-off count in cycles |
| stat_rd | input | 1 | Status read strobe, clears the sticky bits |
| ltime_ok | output | 1 | Registered line-timing grant |
| tx_ref_sel | output | 2 | Transmit reference select |
| stat_los | output | 1 | Sticky loss-of-signal status |
| stat_sync | output | 1 | Sticky sync-error status |
| stat_lof | output | 1 | Sticky loss-of-frame status |
| stat_ais | output | 1 | Sticky line AIS status |

## Verification
Two things can happen in the same cycle: a status read strobe and a live defect that should set the same sticky bit. The bench raises `stat_rd` while `lof` is still 1 and expects `stat_lof` to stay at 1. It then repeats the read with `lof` at 0 and expects the bit to clear. The hold-off count and the request withdrawal can also collide. The bench breaks a qualifying interval part way through and expects the full count to run again before the grant. The qualification logic itself is swept over all 4096 combinations of defects, overrides and polarity, with `vcxo_only` toggled, against an arithmetic model.

// File: rtl/ltime_qual.sv
module ltime_qual #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          los_n,
  input  logic          xfp_inv,
  input  logic          sync_err,
  input  logic          lof,
  input  logic          line_ais,
  input  logic          vco_forced,
  input  logic          sys_loopback,
  input  logic          ovr_los,
  input  logic [1:0]    ovr_sync,
  input  logic          ovr_lof,
  input  logic          ovr_ais,
  input  logic          auto_lt,
  input  logic          force_lt,
  input  logic          vcxo_only,
  input  logic [CW-1:0] holdoff,
  input  logic          stat_rd,
  output logic          ltime_ok,
  output logic [1:0]    tx_ref_sel,
  output logic          stat_los,
  output logic          stat_sync,
  output logic          stat_lof,
  output logic          stat_ais
);

  localparam logic [1:0] SEL_LOCAL = 2'b00;
  localparam logic [1:0] SEL_VCXO  = 2'b01;
  localparam logic [1:0] SEL_LINE  = 2'b10;

  logic          sig_present, no_signal;
  logic          rx_clk_good, want_lt, ok_nxt;
  logic [CW-1:0] qual_cnt;

  assign sig_present = los_n ^ xfp_inv;
  assign no_signal   = ~sig_present;

  assign rx_clk_good = ~vco_forced & ~sys_loopback
                     & (sig_present | ovr_los)
                     & (~sync_err | (ovr_sync == 2'b01))
                     & (~lof | ovr_lof)
                     & (~line_ais | ovr_ais);

  assign want_lt = force_lt | (auto_lt & rx_clk_good);

  always_comb begin
    if (!want_lt)                    ok_nxt = 1'b0;
    else if (force_lt || ltime_ok)   ok_nxt = 1'b1;
    else                             ok_nxt = (qual_cnt == holdoff);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      qual_cnt   <= '0;
      ltime_ok   <= 1'b0;
      tx_ref_sel <= SEL_LOCAL;
    end else begin
      if (!want_lt || ok_nxt) qual_cnt <= '0;
      else                    qual_cnt <= qual_cnt + 1'b1;
      ltime_ok   <= ok_nxt;
      tx_ref_sel <= ok_nxt ? SEL_LINE : (vcxo_only ? SEL_VCXO : SEL_LOCAL);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_los  <= 1'b0;
      stat_sync <= 1'b0;
      stat_lof  <= 1'b0;
      stat_ais  <= 1'b0;
    end else begin
      stat_los  <= no_signal | (stat_los  & ~stat_rd);
      stat_sync <= sync_err  | (stat_sync & ~stat_rd);
      stat_lof  <= lof       | (stat_lof  & ~stat_rd);
      stat_ais  <= line_ais  | (stat_ais  & ~stat_rd);
    end
  end

endmodule

// File: rtl/ltime_qual_chk.sv
module ltime_qual_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       vco_forced,
  input logic       sys_loopback,
  input logic       force_lt,
  input logic       auto_lt,
  input logic       lof,
  input logic       ovr_lof,
  input logic       stat_rd,
  input logic       vcxo_only,
  input logic       ltime_ok,
  input logic [1:0] tx_ref_sel,
  input logic       stat_lof
);

  assert_forced_block_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((vco_forced || sys_loopback) && !force_lt) |=> !ltime_ok);

  assert_lof_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lof && !ovr_lof && !force_lt) |=> !ltime_ok);

  assert_no_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_lt && !auto_lt) |=> !ltime_ok);

  assert_force_now_R6: assert property (@(posedge clk) disable iff (!rst_n)
    force_lt |=> ltime_ok);

  assert_sel_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ltime_ok |-> (tx_ref_sel == 2'b10));

  assert_sel_fallback_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_lt && !auto_lt) |=> (tx_ref_sel == {1'b0, $past(vcxo_only)}));

  assert_sticky_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lof |=> stat_lof);

  assert_sticky_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !lof) |=> !stat_lof);

endmodule

bind ltime_qual ltime_qual_chk u_chk (
  .clk(clk), .rst_n(rst_n), .vco_forced(vco_forced), .sys_loopback(sys_loopback),
  .force_lt(force_lt), .auto_lt(auto_lt), .lof(lof), .ovr_lof(ovr_lof),
  .stat_rd(stat_rd), .vcxo_only(vcxo_only), .ltime_ok(ltime_ok),
  .tx_ref_sel(tx_ref_sel), .stat_lof(stat_lof)
);

// File: tb/ltime_qual_tb.sv
module ltime_qual_tb;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic los_n = 1'b1, xfp_inv = 1'b0, sync_err = 1'b0, lof = 1'b0, line_ais = 1'b0;
  logic vco_forced = 1'b0, sys_loopback = 1'b0;
  logic ovr_los = 1'b0, ovr_lof = 1'b0, ovr_ais = 1'b0;
  logic [1:0] ovr_sync = 2'b00;
  logic auto_lt = 1'b0, force_lt = 1'b0, vcxo_only = 1'b0, stat_rd = 1'b0;
  logic [CW-1:0] holdoff = '0;
  logic ltime_ok, stat_los, stat_sync, stat_lof, stat_ais;
  logic [1:0] tx_ref_sel;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ltime_qual #(.CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .los_n(los_n), .xfp_inv(xfp_inv), .sync_err(sync_err),
    .lof(lof), .line_ais(line_ais), .vco_forced(vco_forced), .sys_loopback(sys_loopback),
    .ovr_los(ovr_los), .ovr_sync(ovr_sync), .ovr_lof(ovr_lof), .ovr_ais(ovr_ais),
    .auto_lt(auto_lt), .force_lt(force_lt), .vcxo_only(vcxo_only), .holdoff(holdoff),
    .stat_rd(stat_rd), .ltime_ok(ltime_ok), .tx_ref_sel(tx_ref_sel),
    .stat_los(stat_los), .stat_sync(stat_sync), .stat_lof(stat_lof), .stat_ais(stat_ais)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    @(negedge clk);
    step(); step();
    // R10 reset state
    chk("R10 ltime_ok", ltime_ok, 0);
    chk("R10 tx_ref_sel", tx_ref_sel, 0);
    chk("R10 status", {stat_los, stat_sync, stat_lof, stat_ais}, 0);
    rst_n = 1'b1;

    // R1..R5, R8: exhaustive qualification sweep with hold-off 0
    auto_lt = 1'b1;
    for (int i = 0; i < 8192; i++) begin
      bit good;
      bit [1:0] esel;
      vco_forced   = i[0];
      sys_loopback = i[1];
      los_n        = i[2];
      xfp_inv      = i[3];
      ovr_los      = i[4];
      sync_err     = i[5];
      ovr_sync     = i[7:6];
      lof          = i[8];
      ovr_lof      = i[9];
      line_ais     = i[10];
      ovr_ais      = i[11];
      vcxo_only    = i[12];
      good = !i[0] && !i[1] && ((i[2] != i[3]) || i[4]) &&
             (!i[5] || (i[7:6] == 2'd1)) && (!i[8] || i[9]) && (!i[10] || i[11]);
      esel = good ? 2'd2 : (i[12] ? 2'd1 : 2'd0);
      step();
      chk("R1 R2 R3 R4 R5 sweep ltime_ok", ltime_ok, int'(good));
      chk("R8 sweep tx_ref_sel", tx_ref_sel, esel);
    end

    // clean defect-free setting
    vco_forced = 0; sys_loopback = 0; los_n = 1; xfp_inv = 0; ovr_los = 0;
    sync_err = 0; ovr_sync = 0; lof = 0; ovr_lof = 0; line_ais = 0; ovr_ais = 0;
    vcxo_only = 0;

    // R5: no enable
    auto_lt = 0; step();
    chk("R5 auto off", ltime_ok, 0);

    // R7: hold-off of 5
    holdoff = 5; vco_forced = 1; auto_lt = 1; step();
    chk("R7 blocked", ltime_ok, 0);
    vco_forced = 0;
    for (int k = 0; k < 5; k++) begin step(); chk("R7 holding", ltime_ok, 0); end
    step(); chk("R7 granted", ltime_ok, 1);
    chk("R8 line select", tx_ref_sel, 2);
    lof = 1; step(); chk("R7 drop", ltime_ok, 0);
    lof = 0;
    for (int k = 0; k < 3; k++) begin step(); chk("R7 partial", ltime_ok, 0); end
    line_ais = 1; step(); chk("R7 break", ltime_ok, 0);
    line_ais = 0;
    for (int k = 0; k < 5; k++) begin step(); chk("R7 restart", ltime_ok, 0); end
    step(); chk("R7 regrant", ltime_ok, 1);

    // R6: force with defects present, bypassing hold-off
    vco_forced = 1; step(); chk("R6 pre", ltime_ok, 0);
    force_lt = 1; auto_lt = 0; step();
    chk("R6 forced", ltime_ok, 1);
    chk("R6 forced sel", tx_ref_sel, 2);
    force_lt = 0; vcxo_only = 1; step();
    chk("R8 vcxo fallback", tx_ref_sel, 1);
    vco_forced = 0; vcxo_only = 0; holdoff = 0;

    // R9: sticky status with read colliding with live defect
    stat_rd = 1; step(); stat_rd = 0; step();
    chk("R9 cleared", {stat_los, stat_sync, stat_lof, stat_ais}, 0);
    lof = 1; step(); lof = 0; step();
    chk("R9 lof latched", stat_lof, 1);
    step(); chk("R9 lof held", stat_lof, 1);
    lof = 1; stat_rd = 1; step();
    chk("R9 read with live defect", stat_lof, 1);
    lof = 0; step();
    chk("R9 read clears", stat_lof, 0);
    stat_rd = 0;
    ovr_los = 1; los_n = 0; sync_err = 1; ovr_sync = 2'b01; line_ais = 1; ovr_ais = 1;
    step();
    los_n = 1; sync_err = 0; line_ais = 0; step();
    chk("R9 los latched despite override", stat_los, 1);
    chk("R9 sync latched", stat_sync, 1);
    chk("R9 ais latched", stat_ais, 1);
    stat_rd = 1; step(); stat_rd = 0;
    chk("R9 all cleared", {stat_los, stat_sync, stat_lof, stat_ais}, 0);

    finish_run();
  end
endmodule